// File: doc/BRIEF.md
# Flash Operation Status Generator

This block holds the status side of a NOR-style flash model. It follows an embedded program or erase from the moment the command is accepted until it finishes, and it tracks an erase that is suspended. It also tracks a program that runs while an erase is suspended. Array storage, command decoding and analog timing are outside this block. Each operation lasts for a number of clock cycles set by parameters. The windows for operations that hit protected sectors are derived from the clock frequency in MHz, as 2 µs for a program and 100 µs for an erase.

A read returns either the array data presented on `array_data_i` or a status word. The status word carries two toggle bits and zeros elsewhere. Software polls the status word to learn whether an operation is still running. It also learns whether a given sector is being erased or is erase-suspended. A single ready/busy line, low while busy, models an open-drain pin.

A sector is numbered by the top `log2(NUM_SECTORS)` address bits.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle, `rdy_bsy_no` is 1, and a read returns `array_data_i`.
- R2: An accepted program keeps `rdy_bsy_no` at 0 for exactly PROG_CYCLES clock edges after the accepting edge. After those edges the block returns to idle.
- R3: An erase acts only on the selected sectors that are not protected (`erase_sel_i & ~protect_i`). It lasts ERASE_CYCLES times the number of those sectors.
- R4: Bit 6 of the status word flips on every read to any address while a program or erase is busy. The first read after leaving idle returns 1.
- R5: Bit 2 of the status word flips only on reads whose sector lies in the effective erase set. This holds during active erase, erase suspend, and a program inside suspend. On all other reads bit 2 keeps its value.
- R6: In idle, reads return `array_data_i`. Both toggle bits are cleared to 0 whenever the block is idle.
- R7: A suspend during an erase enters erase suspend on the next edge. In suspend, `rdy_bsy_no` is 1, the remaining erase time is frozen, and bit 6 holds. A read outside the erase set returns array data. A read inside the erase set returns the status word.
- R8: A program accepted in erase suspend holds `rdy_bsy_no` at 0 for PROG_CYCLES edges and toggles bit 6. The block then returns to suspend. A resume continues the erase, and the erase time spent before and after the suspend adds up to the R3 duration.
- R9: A program whose address is in a protected sector is busy and toggles bit 6 for 2*CLK_MHZ edges, then returns to idle.
- R10: An erase with no unprotected sector selected is busy and toggles bit 6 for 100*CLK_MHZ edges. Bit 2 stays at 0 throughout.
- R11: The block ignores these commands: erase start when not idle, program start during a busy operation, suspend outside a running unprotected erase, and resume outside erase suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | One-cycle program start event |
| prog_addr_i | input | ADDR_W | Program target address |
| erase_start_i | input | 1 | One-cycle erase start event |
| erase_sel_i | input | NUM_SECTORS | Sectors chosen for erase |
| protect_i | input | NUM_SECTORS | Protected sectors |
| suspend_i | input | 1 | One-cycle erase suspend event |
| resume_i | input | 1 | One-cycle erase resume event |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | DATA_W | Array data returned in array-read mode |
| rd_data_o | output | DATA_W | Read result, registered on the strobe edge |
| rdy_bsy_no | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions check the cycle-level rules on every cycle:
- the remaining erase time stays frozen in suspend;
- bit 6 flips on busy reads and holds in suspend;
- bit 2 does not move on unqualified reads;
- the toggle bits are cleared in idle;
- a program inside suspend returns to suspend;
- commands that arrive in the wrong state are dropped.

Only the bench scenarios can show the end-to-end durations: the R3 scaling with the unprotected sector count, the protected-sector windows, and how the erase time splits around a suspend. The bench scenarios also show the exact status words software sees across a chain of reads.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SUSP_PROG
  } op_state_e;

  localparam int unsigned TB_ANY_BIT  = 6;
  localparam int unsigned TB_SECT_BIT = 2;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned ADDR_W      = 16
) (
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [NUM_SECTORS-1:0] hit_o
);
  localparam int unsigned SECT_W = $clog2(NUM_SECTORS);

  logic [SECT_W-1:0] sect_idx;
  assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_hit
    assign hit_o[g] = (sect_idx == SECT_W'(g));
  end

endmodule

// File: rtl/flash_op_fsm.sv
module flash_op_fsm
  import flash_status_pkg::*;
#(
  parameter int unsigned NUM_SECTORS       = 8,
  parameter int unsigned PROG_CYCLES       = 400,
  parameter int unsigned ERASE_CYCLES      = 2000,
  parameter int unsigned PROT_PROG_CYCLES  = 100,
  parameter int unsigned PROT_ERASE_CYCLES = 5000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prog_start_i,
  input  logic [NUM_SECTORS-1:0] prog_hit_i,
  input  logic                   erase_start_i,
  input  logic [NUM_SECTORS-1:0] erase_sel_i,
  input  logic [NUM_SECTORS-1:0] protect_i,
  input  logic                   suspend_i,
  input  logic                   resume_i,
  output op_state_e              state_o,
  output logic [NUM_SECTORS-1:0] erase_mask_o
);
  localparam int unsigned MAX_E = max_u(ERASE_CYCLES * NUM_SECTORS, PROT_ERASE_CYCLES);
  localparam int unsigned MAX_P = max_u(PROG_CYCLES, PROT_PROG_CYCLES);
  localparam int unsigned EW    = $clog2(MAX_E + 1);
  localparam int unsigned PW    = $clog2(MAX_P + 1);
  localparam int unsigned CW    = $clog2(NUM_SECTORS + 1);

  op_state_e              state_q, state_d;
  logic [EW-1:0]          ecnt_q, ecnt_d;
  logic [PW-1:0]          pcnt_q, pcnt_d;
  logic [NUM_SECTORS-1:0] mask_q, mask_d;
  logic                   eprot_q, eprot_d;

  logic [NUM_SECTORS-1:0] eff_sel;
  logic [CW-1:0]          n_unprot;
  logic [EW-1:0]          erase_len;
  logic [PW-1:0]          prog_len;
  logic                   prog_prot;

  assign eff_sel   = erase_sel_i & ~protect_i;
  assign prog_prot = |(prog_hit_i & protect_i);

  always_comb begin
    n_unprot = '0;
    for (int i = 0; i < NUM_SECTORS; i++) n_unprot = n_unprot + CW'(eff_sel[i]);
  end

  // lengths are loaded minus one: the terminal edge is the last busy edge
  assign erase_len = (n_unprot == '0) ? EW'(PROT_ERASE_CYCLES - 1)
                                      : EW'(int'(n_unprot) * ERASE_CYCLES - 1);
  assign prog_len  = prog_prot ? PW'(PROT_PROG_CYCLES - 1) : PW'(PROG_CYCLES - 1);

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    pcnt_d  = pcnt_q;
    mask_d  = mask_q;
    eprot_d = eprot_q;
    unique case (state_q)
      ST_IDLE: begin
        if (prog_start_i) begin
          state_d = ST_PROG;
          pcnt_d  = prog_len;
        end else if (erase_start_i) begin
          state_d = ST_ERASE;
          ecnt_d  = erase_len;
          mask_d  = eff_sel;
          eprot_d = (n_unprot == '0);
        end
      end
      ST_PROG: begin
        if (pcnt_q == '0) state_d = ST_IDLE;
        else              pcnt_d  = pcnt_q - 1'b1;
      end
      ST_ERASE: begin
        if (suspend_i && !eprot_q) begin
          state_d = ST_SUSP;
        end else if (ecnt_q == '0) begin
          state_d = ST_IDLE;
          mask_d  = '0;
          eprot_d = 1'b0;
        end else begin
          ecnt_d = ecnt_q - 1'b1;
        end
      end
      ST_SUSP: begin
        if (prog_start_i) begin
          state_d = ST_SUSP_PROG;
          pcnt_d  = prog_len;
        end else if (resume_i) begin
          state_d = ST_ERASE;
        end
      end
      ST_SUSP_PROG: begin
        if (pcnt_q == '0) state_d = ST_SUSP;
        else              pcnt_d  = pcnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      pcnt_q  <= '0;
      mask_q  <= '0;
      eprot_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      pcnt_q  <= pcnt_d;
      mask_q  <= mask_d;
      eprot_q <= eprot_d;
    end
  end

  assign state_o      = state_q;
  assign erase_mask_o = mask_q;

  p_susp_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && $past(state_q) == ST_SUSP) |-> $stable(ecnt_q))
    else $error("erase time moved during suspend");

  p_prog_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_SUSP_PROG && state_q != ST_SUSP_PROG) |-> state_q == ST_SUSP)
    else $error("program in suspend did not return to suspend");

  p_prog_no_erase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG) |=> (state_q == ST_PROG || state_q == ST_IDLE))
    else $error("command accepted during program");

  p_idle_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (mask_q == '0))
    else $error("erase set left over in idle");

endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  op_state_e              state_i,
  input  logic                   rd_i,
  input  logic [NUM_SECTORS-1:0] rd_hit_i,
  input  logic [NUM_SECTORS-1:0] erase_mask_i,
  input  logic [DATA_W-1:0]      array_data_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  logic              tb_any_q, tb_any_d;
  logic              tb_sect_q, tb_sect_d;
  logic [DATA_W-1:0] rd_data_q;
  logic              busy, erase_pend, in_set, status_rd;
  logic [DATA_W-1:0] status_word;

  assign busy       = (state_i == ST_PROG) || (state_i == ST_ERASE) || (state_i == ST_SUSP_PROG);
  assign erase_pend = (state_i == ST_ERASE) || (state_i == ST_SUSP) || (state_i == ST_SUSP_PROG);
  assign in_set     = |(rd_hit_i & erase_mask_i);
  assign status_rd  = busy || ((state_i == ST_SUSP) && in_set);

  always_comb begin
    tb_any_d  = tb_any_q;
    tb_sect_d = tb_sect_q;
    if (state_i == ST_IDLE) begin
      tb_any_d  = 1'b0;
      tb_sect_d = 1'b0;
    end else if (rd_i) begin
      if (busy)                tb_any_d  = ~tb_any_q;
      if (erase_pend && in_set) tb_sect_d = ~tb_sect_q;
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[TB_ANY_BIT]  = tb_any_d;
    status_word[TB_SECT_BIT] = tb_sect_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_any_q  <= 1'b0;
      tb_sect_q <= 1'b0;
      rd_data_q <= '0;
    end else begin
      tb_any_q  <= tb_any_d;
      tb_sect_q <= tb_sect_d;
      if (rd_i) rd_data_q <= status_rd ? status_word : array_data_i;
    end
  end

  assign rd_data_o = rd_data_q;

  p_any_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy) |=> (tb_any_q != $past(tb_any_q)))
    else $error("bit 6 did not flip on busy read");

  p_sect_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_set && state_i != ST_IDLE) |=> $stable(tb_sect_q))
    else $error("bit 2 moved on unqualified read");

  p_idle_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_IDLE) |-> (!tb_any_q && !tb_sect_q))
    else $error("toggle bits not cleared in idle");

  p_idle_array_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_IDLE) |=> (rd_data_o == $past(array_data_i)))
    else $error("idle read did not return array data");

  p_susp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SUSP) |=> $stable(tb_any_q))
    else $error("bit 6 moved in suspend");

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_status_pkg::*;
#(
  parameter int unsigned NUM_SECTORS  = 8,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_MHZ      = 50,
  parameter int unsigned PROG_CYCLES  = 400,
  parameter int unsigned ERASE_CYCLES = 2000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prog_start_i,
  input  logic [ADDR_W-1:0]      prog_addr_i,
  input  logic                   erase_start_i,
  input  logic [NUM_SECTORS-1:0] erase_sel_i,
  input  logic [NUM_SECTORS-1:0] protect_i,
  input  logic                   suspend_i,
  input  logic                   resume_i,
  input  logic                   rd_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [DATA_W-1:0]      array_data_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   rdy_bsy_no
);
  localparam int unsigned PROT_PROG_CYCLES  = 2 * CLK_MHZ;
  localparam int unsigned PROT_ERASE_CYCLES = 100 * CLK_MHZ;

  op_state_e              state;
  logic [NUM_SECTORS-1:0] prog_hit, rd_hit, erase_mask;

  flash_sector_map #(.NUM_SECTORS(NUM_SECTORS), .ADDR_W(ADDR_W)) i_prog_map (
    .addr_i(prog_addr_i),
    .hit_o (prog_hit)
  );

  flash_sector_map #(.NUM_SECTORS(NUM_SECTORS), .ADDR_W(ADDR_W)) i_rd_map (
    .addr_i(rd_addr_i),
    .hit_o (rd_hit)
  );

  flash_op_fsm #(
    .NUM_SECTORS      (NUM_SECTORS),
    .PROG_CYCLES      (PROG_CYCLES),
    .ERASE_CYCLES     (ERASE_CYCLES),
    .PROT_PROG_CYCLES (PROT_PROG_CYCLES),
    .PROT_ERASE_CYCLES(PROT_ERASE_CYCLES)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_i),
    .prog_hit_i   (prog_hit),
    .erase_start_i(erase_start_i),
    .erase_sel_i  (erase_sel_i),
    .protect_i    (protect_i),
    .suspend_i    (suspend_i),
    .resume_i     (resume_i),
    .state_o      (state),
    .erase_mask_o (erase_mask)
  );

  flash_toggle_gen #(.NUM_SECTORS(NUM_SECTORS), .DATA_W(DATA_W)) i_toggle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .rd_i        (rd_i),
    .rd_hit_i    (rd_hit),
    .erase_mask_i(erase_mask),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );

  // pulled low only while an algorithm runs; suspend counts as ready
  assign rdy_bsy_no = !((state == ST_PROG) || (state == ST_ERASE) || (state == ST_SUSP_PROG));

  p_ready_in_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ERASE && suspend_i && rdy_bsy_no == 1'b0 && $past(state) == ST_ERASE
     && erase_mask != '0) |=> rdy_bsy_no)
    else $error("ready not restored on suspend");

endmodule

// File: tb/test_flash_op_status.sv
module test_flash_op_status;
  localparam int unsigned NS = 8;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam int unsigned MHZ = 4;
  localparam int unsigned PROG_C = 20;
  localparam int unsigned ERASE_C = 30;
  localparam int unsigned PPROG_C = 2 * MHZ;
  localparam int unsigned PERASE_C = 100 * MHZ;
  localparam logic [DW-1:0] ARRAY = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_start = 1'b0, erase_start = 1'b0, suspend = 1'b0, resume = 1'b0, rd = 1'b0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [NS-1:0] erase_sel = '0, protect = '0;
  logic [DW-1:0] rd_data;
  logic rdy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_op_status #(
    .NUM_SECTORS(NS), .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ),
    .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)
  ) i_flash_op_status (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .prog_addr_i(prog_addr),
    .erase_start_i(erase_start), .erase_sel_i(erase_sel), .protect_i(protect),
    .suspend_i(suspend), .resume_i(resume), .rd_i(rd), .rd_addr_i(rd_addr),
    .array_data_i(ARRAY), .rd_data_o(rd_data), .rdy_bsy_no(rdy)
  );

  function automatic logic [AW-1:0] sect(int s);
    return {3'(s), 13'h0};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_at(int s, output logic [DW-1:0] v);
    rd = 1'b1;
    rd_addr = sect(s);
    @(negedge clk);
    rd = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse_prog(int s);
    prog_addr = sect(s);
    prog_start = 1'b1;
    @(negedge clk);
    prog_start = 1'b0;
  endtask

  task automatic pulse_erase(logic [NS-1:0] sel);
    erase_sel = sel;
    erase_start = 1'b1;
    @(negedge clk);
    erase_start = 1'b0;
  endtask

  task automatic pulse_susp();
    suspend = 1'b1;
    @(negedge clk);
    suspend = 1'b0;
  endtask

  task automatic pulse_res();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic wait_ready(output int t);
    for (int i = 0; i < 5000 && rdy == 1'b0; i++) @(negedge clk);
    t = cyc;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 ready after reset", int'(rdy), 1);
    rd_at(3, v);
    chk("R1 reset read array", int'(v), int'(ARRAY));
  endtask

  task automatic t_program();
    logic [DW-1:0] v;
    int t0, te;
    protect = 8'h80;
    pulse_prog(1);
    t0 = cyc;
    chk("R2 busy after start", int'(rdy), 0);
    rd_at(0, v); chk("R4 first read", int'(v), 8'h40);
    rd_at(5, v); chk("R4 second read", int'(v), 8'h00);
    rd_at(1, v); chk("R4 third read", int'(v), 8'h40);
    wait_ready(te);
    chk("R2 program length", te - t0, PROG_C);
    rd_at(1, v); chk("R6 idle read array", int'(v), int'(ARRAY));
  endtask

  task automatic t_ignore_busy();
    int t0, te;
    pulse_prog(2);
    t0 = cyc;
    pulse_erase(8'h01);
    pulse_susp();
    pulse_prog(3);
    pulse_res();
    wait_ready(te);
    chk("R11 program length unchanged", te - t0, PROG_C);
    repeat (3) @(negedge clk);
    chk("R11 no late start", int'(rdy), 1);
    pulse_susp();
    pulse_res();
    chk("R11 idle suspend/resume ignored", int'(rdy), 1);
  endtask

  task automatic t_erase_partial();
    logic [DW-1:0] v;
    int t0, te;
    protect = 8'h80;
    pulse_erase(8'h86);
    t0 = cyc;
    rd_at(1, v); chk("R5 read in set", int'(v), 8'h44);
    rd_at(3, v); chk("R5 read outside set", int'(v), 8'h04);
    rd_at(7, v); chk("R3 protected sector not in set", int'(v), 8'h44);
    rd_at(2, v); chk("R5 read in set again", int'(v), 8'h00);
    wait_ready(te);
    chk("R3 erase length two sectors", te - t0, 2 * ERASE_C);
  endtask

  task automatic t_suspend();
    logic [DW-1:0] v;
    int t0, ts, tp, tq, tr, te;
    protect = '0;
    pulse_erase(8'h01);
    t0 = cyc;
    repeat (4) @(negedge clk);
    rd_at(0, v); chk("R4 erase read", int'(v), 8'h44);
    pulse_susp();
    ts = cyc;
    chk("R7 ready in suspend", int'(rdy), 1);
    repeat (5) @(negedge clk);
    rd_at(5, v); chk("R7 array read outside set", int'(v), int'(ARRAY));
    rd_at(0, v); chk("R7 status in set, bit6 held", int'(v), 8'h40);
    pulse_prog(4);
    tp = cyc;
    chk("R8 busy in suspend program", int'(rdy), 0);
    pulse_res();
    rd_at(4, v); chk("R8 suspend program read", int'(v), 8'h00);
    rd_at(0, v); chk("R8 suspend program read in set", int'(v), 8'h44);
    wait_ready(tq);
    chk("R8 suspend program length", tq - tp, PROG_C);
    repeat (4) @(negedge clk);
    chk("R11 resume during program ignored", int'(rdy), 1);
    pulse_res();
    tr = cyc;
    chk("R8 busy after resume", int'(rdy), 0);
    rd_at(0, v); chk("R8 read after resume", int'(v), 8'h00);
    wait_ready(te);
    chk("R8 erase time across suspend", (ts - t0 - 1) + (te - tr), ERASE_C);
  endtask

  task automatic t_prot_prog();
    logic [DW-1:0] v;
    int t0, te;
    protect = 8'h02;
    pulse_prog(1);
    t0 = cyc;
    rd_at(6, v); chk("R9 protected program toggles", int'(v), 8'h40);
    wait_ready(te);
    chk("R9 protected program window", te - t0, PPROG_C);
  endtask

  task automatic t_prot_erase();
    logic [DW-1:0] v;
    int t0, te;
    protect = 8'h06;
    pulse_erase(8'h06);
    t0 = cyc;
    rd_at(1, v); chk("R10 read bit2 stays 0", int'(v), 8'h40);
    rd_at(2, v); chk("R10 second read", int'(v), 8'h00);
    pulse_susp();
    chk("R11 suspend ignored in protected erase", int'(rdy), 0);
    wait_ready(te);
    chk("R10 protected erase window", te - t0, PERASE_C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_ignore_busy();
    t_erase_partial();
    t_suspend();
    t_prot_prog();
    t_prot_erase();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule